// File: doc/BRIEF.md
# Open-Row-First DRAM Bank Scheduler

This block orders memory requests for one DRAM channel that has four banks. Each request carries a 32-bit physical byte address, an application id and a tag. The block decodes the bank and row fields from the address and keeps the request in a small buffer that records arrival order. At most one request leaves the buffer on each clock edge. A request whose row is already open in its bank goes first. If none is ready, the oldest request whose bank is free goes. The block models the row buffer of each bank, so a bank keeps the last row it accessed open.

A bank serves one request at a time. A request that hits the open row holds its bank for `SVC_T` cycles. A request to a closed bank, or to a different row, holds the bank for `2*SVC_T` cycles. When service ends, the completion lane of that bank pulses for one cycle and returns the tag, the application id and whether the access was a row hit. A static parameter selects one of two address layouts. Because open-row hits go ahead of older requests, a long run of hits to one row can hold back another application for many service slots.

Top module: `rowhit_sched`

## Requirements
- R1: With `ALT_MAP`=0, the bank is `addr[13:12]` and the row is `addr[31:14]`. Bits `[11:10]` and `[9:0]` change neither the bank chosen nor the row-hit outcome. A request served in bank b completes on lane b.
- R2: With `ALT_MAP`=1, the bank is `addr[11:10]` and the row is `addr[31:14]`. Bits `[13:12]` do not affect the row-hit outcome.
- R3: The buffer holds `DEPTH` requests. `req_ready` is 1 exactly when fewer than `DEPTH` are held. A request is taken on an edge where `req_valid` and `req_ready` are both 1. A push offered while `req_ready` is 0 is dropped.
- R4: A request that hits the open row of its bank occupies the bank for `SVC_T` cycles. Any other request occupies it for `2*SVC_T` cycles. After reset no bank has an open row.
- R5: Among buffered requests whose bank can start, the oldest one that hits its bank's open row is issued. If no such request exists, the oldest one whose bank can start is issued.
- R6: A request stored on edge e can issue on edge e+1 at the earliest. A bank that issued on edge k can take its next request on edge k+duration.
- R7: A request issued on edge k with duration d raises `cmp_valid[b]` for the single cycle that follows edge k+d. In that cycle it shows the request's tag and application id, and `cmp_hit[b]`=1 exactly when the request was a row hit.
- R8: At most one request is issued per edge across all banks.
- R9: Issuing a request opens its row in its bank. The row stays open until another row is issued to that bank.
- R10: After reset, `req_ready` is 1 and no completion lane is active.
- R11: Take a closed or other-row bank and push, in this order: 16 requests to row A interleaved with 3 requests to row B of the same bank, with the first A request oldest. The last A request completes 17*`SVC_T` cycles after the first issue, and the last B request 21*`SVC_T` cycles after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Push request |
| req_ready | output | 1 | Buffer has a free entry |
| req_addr | input | 32 | Physical byte address |
| req_app | input | APP_W | Application id |
| req_tag | input | TAG_W | Request tag |
| cmp_valid | output | 4 | Per-bank completion pulse |
| cmp_tag | output | 4*TAG_W | Per-bank completed tag, lane b at [b*TAG_W +: TAG_W] |
| cmp_app | output | 4*APP_W | Per-bank completed application id |
| cmp_hit | output | 4 | Per-bank: the completed request was a row hit |

## Verification
The embedded properties assume that reset is applied before the first push. They also assume that `SVC_T` is at least 1, so that a reload value is never zero. Apart from that they accept any push pattern, including pushes offered while the buffer is full. The stimulus stays inside these limits: it holds reset for several cycles and then drives the push port only on falling edges. Traffic is restricted to a few rows per bank, so hits, conflicts, back-pressure and simultaneous waiting across banks all occur.

// File: rtl/rowhit_sched.sv
module rowhit_sched #(
  parameter int DEPTH   = 16,
  parameter int SVC_T   = 4,
  parameter int TAG_W   = 6,
  parameter int APP_W   = 2,
  parameter bit ALT_MAP = 1'b0,
  localparam int NBANK  = 4
)(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [31:0]            req_addr,
  input  logic [APP_W-1:0]       req_app,
  input  logic [TAG_W-1:0]       req_tag,
  output logic [NBANK-1:0]       cmp_valid,
  output logic [NBANK*TAG_W-1:0] cmp_tag,
  output logic [NBANK*APP_W-1:0] cmp_app,
  output logic [NBANK-1:0]       cmp_hit
);
  localparam int BANK_W   = 2;
  localparam int ROW_LSB  = 14;
  localparam int ROW_W    = 32 - ROW_LSB;
  localparam int BANK_LSB = ALT_MAP ? 10 : 12;
  localparam int LONG     = 2 * SVC_T;
  localparam int CNT_W    = $clog2(LONG + 1);
  localparam int IDX_W    = $clog2(DEPTH);
  localparam int OCC_W    = $clog2(DEPTH + 1);

  logic [BANK_W-1:0] q_bank [DEPTH];
  logic [ROW_W-1:0]  q_row  [DEPTH];
  logic [TAG_W-1:0]  q_tag  [DEPTH];
  logic [APP_W-1:0]  q_app  [DEPTH];
  logic [OCC_W-1:0]  occ;

  logic [CNT_W-1:0]  cnt      [NBANK];
  logic              open_v   [NBANK];
  logic [ROW_W-1:0]  open_row [NBANK];
  logic [TAG_W-1:0]  cur_tag  [NBANK];
  logic [APP_W-1:0]  cur_app  [NBANK];
  logic              cur_hit  [NBANK];
  logic [TAG_W-1:0]  out_tag  [NBANK];
  logic [APP_W-1:0]  out_app  [NBANK];

  logic [BANK_W-1:0] in_bank;
  logic [ROW_W-1:0]  in_row;
  logic              addr_unused;
  logic              push;
  logic              iss_v, iss_hit, any_f, hit_f;
  logic [IDX_W-1:0]  iss_i, any_i, hit_i;
  logic [BANK_W-1:0] iss_bank;
  logic [ROW_W-1:0]  iss_row;
  logic [OCC_W-1:0]  wp;

  assign in_bank     = req_addr[BANK_LSB +: BANK_W];
  assign in_row      = req_addr[31:ROW_LSB];
  assign addr_unused = ^req_addr[ROW_LSB-1:0];
  assign req_ready   = occ < OCC_W'(DEPTH);
  assign push        = req_valid && req_ready;

  always_comb begin
    any_f = 1'b0;
    hit_f = 1'b0;
    any_i = '0;
    hit_i = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (OCC_W'(i) < occ && cnt[q_bank[i]] <= CNT_W'(1)) begin
        if (!any_f) begin
          any_f = 1'b1;
          any_i = IDX_W'(i);
        end
        if (!hit_f && open_v[q_bank[i]] && open_row[q_bank[i]] == q_row[i]) begin
          hit_f = 1'b1;
          hit_i = IDX_W'(i);
        end
      end
    end
  end

  assign iss_v    = any_f;
  assign iss_hit  = hit_f;
  assign iss_i    = hit_f ? hit_i : any_i;
  assign iss_bank = q_bank[iss_i];
  assign iss_row  = q_row[iss_i];
  assign wp       = occ - OCC_W'(iss_v);

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (push && OCC_W'(i) == wp) begin
        q_bank[i] <= in_bank;
        q_row[i]  <= in_row;
        q_tag[i]  <= req_tag;
        q_app[i]  <= req_app;
      end else if (iss_v && i >= int'(iss_i) && i < DEPTH - 1) begin
        q_bank[i] <= q_bank[i+1];
        q_row[i]  <= q_row[i+1];
        q_tag[i]  <= q_tag[i+1];
        q_app[i]  <= q_app[i+1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ <= '0;
    else        occ <= occ + OCC_W'(push) - OCC_W'(iss_v);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_valid <= '0;
      cmp_hit   <= '0;
      for (int b = 0; b < NBANK; b++) begin
        cnt[b]      <= '0;
        open_v[b]   <= 1'b0;
        open_row[b] <= '0;
        cur_tag[b]  <= '0;
        cur_app[b]  <= '0;
        cur_hit[b]  <= 1'b0;
        out_tag[b]  <= '0;
        out_app[b]  <= '0;
      end
    end else begin
      for (int b = 0; b < NBANK; b++) begin
        cmp_valid[b] <= cnt[b] == CNT_W'(1);
        if (cnt[b] == CNT_W'(1)) begin
          out_tag[b] <= cur_tag[b];
          out_app[b] <= cur_app[b];
          cmp_hit[b] <= cur_hit[b];
        end
        if (iss_v && iss_bank == BANK_W'(b)) begin
          cnt[b]      <= iss_hit ? CNT_W'(SVC_T) : CNT_W'(LONG);
          open_v[b]   <= 1'b1;
          open_row[b] <= iss_row;
          cur_tag[b]  <= q_tag[iss_i];
          cur_app[b]  <= q_app[iss_i];
          cur_hit[b]  <= iss_hit;
        end else if (cnt[b] != '0) begin
          cnt[b] <= cnt[b] - CNT_W'(1);
        end
      end
    end
  end

  AST_OCC_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) occ <= OCC_W'(DEPTH)); // R3
  AST_PUSH_HELD: assert property (@(posedge clk) disable iff (!rst_n) push |=> occ != '0); // R3

  for (genvar g = 0; g < NBANK; g++) begin : g_lane
    assign cmp_tag[g*TAG_W +: TAG_W] = out_tag[g];
    assign cmp_app[g*APP_W +: APP_W] = out_app[g];

    AST_RELOAD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_v && iss_bank == BANK_W'(g)) |=> (cnt[g] == CNT_W'(SVC_T) || cnt[g] == CNT_W'(LONG))); // R4
    AST_ROW_OPENED: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_v && iss_bank == BANK_W'(g)) |=> (open_v[g] && open_row[g] == $past(iss_row))); // R9
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) cnt[g] <= CNT_W'(LONG)); // R6
    AST_CMP_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmp_valid[g]) |-> $past(cnt[g]) == CNT_W'(1)); // R7
  end
endmodule

// File: tb/rowhit_sched_bench.sv
`timescale 1ns/1ps
module rowhit_sched_bench;
  localparam int T = 4;
  localparam int D = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, alt_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_app = '0;
  logic [5:0]  req_tag = '0;
  logic        req_ready, a_ready;
  logic [3:0]  cmp_valid, cmp_hit, a_cv, a_ch;
  logic [23:0] cmp_tag, a_ct;
  logic [7:0]  cmp_app, a_ca;

  rowhit_sched #(.DEPTH(D), .SVC_T(T), .TAG_W(6), .APP_W(2), .ALT_MAP(1'b0)) u_rowhit_sched (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_app(req_app), .req_tag(req_tag), .cmp_valid(cmp_valid), .cmp_tag(cmp_tag),
    .cmp_app(cmp_app), .cmp_hit(cmp_hit));

  rowhit_sched #(.DEPTH(D), .SVC_T(T), .TAG_W(6), .APP_W(2), .ALT_MAP(1'b1)) u_alt (
    .clk(clk), .rst_n(rst_n), .req_valid(alt_valid), .req_ready(a_ready), .req_addr(req_addr),
    .req_app(req_app), .req_tag(req_tag), .cmp_valid(a_cv), .cmp_tag(a_ct),
    .cmp_app(a_ca), .cmp_hit(a_ch));

  always #10 clk = ~clk;

  int cyc = 0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", r, act, exp, cyc);
    end
  endtask

  // behavioural reference: one entry list in arrival order, per-bank timers
  typedef struct { int bank; int row; int tag; int app; } ment_t;
  ment_t mq[$];
  int m_cnt[4], m_ov[4], m_row[4], m_tag[4], m_app[4], m_hit[4];
  int e_cv[4], e_tag[4], e_app[4], e_hit[4];
  int e_ready = 1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq.delete();
      for (int b = 0; b < 4; b++) begin
        m_cnt[b] = 0; m_ov[b] = 0; e_cv[b] = 0;
      end
      e_ready = 1;
    end else begin
      int pa, ph, sel, bk;
      bit pok;
      ment_t ne;
      for (int b = 0; b < 4; b++) begin
        e_cv[b] = (m_cnt[b] == 1);
        if (e_cv[b] != 0) begin
          e_tag[b] = m_tag[b]; e_app[b] = m_app[b]; e_hit[b] = m_hit[b];
        end
      end
      pa = -1; ph = -1;
      foreach (mq[i]) begin
        bk = mq[i].bank;
        if (m_cnt[bk] <= 1) begin
          if (pa < 0) pa = i;
          if (ph < 0 && m_ov[bk] != 0 && m_row[bk] == mq[i].row) ph = i;
        end
      end
      pok = req_valid && (mq.size() < D);
      for (int b = 0; b < 4; b++) if (m_cnt[b] > 0) m_cnt[b]--;
      sel = (ph >= 0) ? ph : pa;
      if (sel >= 0) begin
        bk = mq[sel].bank;
        m_cnt[bk] = (ph >= 0) ? T : 2 * T;
        m_hit[bk] = (ph >= 0);
        m_ov[bk]  = 1;
        m_row[bk] = mq[sel].row;
        m_tag[bk] = mq[sel].tag;
        m_app[bk] = mq[sel].app;
        mq.delete(sel);
      end
      if (pok) begin
        ne.bank = int'(req_addr[13:12]);
        ne.row  = int'(req_addr[31:14]);
        ne.tag  = int'(req_tag);
        ne.app  = int'(req_app);
        mq.push_back(ne);
      end
      e_ready = (mq.size() < D);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(req_ready == e_ready[0], "R3 ready vs model", req_ready, e_ready);
      for (int b = 0; b < 4; b++) begin
        chk(cmp_valid[b] == e_cv[b][0], "R5 R6 R7 R8 lane valid vs model", cmp_valid[b], e_cv[b]);
        if (e_cv[b] != 0) begin
          chk(int'(cmp_tag[b*6 +: 6]) == e_tag[b], "R5 R7 R8 tag vs model", cmp_tag[b*6 +: 6], e_tag[b]);
          chk(int'(cmp_app[b*2 +: 2]) == e_app[b], "R7 app vs model", cmp_app[b*2 +: 2], e_app[b]);
          chk(cmp_hit[b] == e_hit[b][0], "R4 R9 hit vs model", cmp_hit[b], e_hit[b]);
        end
      end
    end
  end

  function automatic logic [31:0] mk(input int row, input int hi, input int mid, input int blk);
    return (32'(row) << 14) | (32'(hi) << 12) | (32'(mid) << 10) | (32'(blk) << 6);
  endfunction

  task automatic push(input bit alt, input logic [31:0] a, input int app, input int tag,
                      input bit keep, output int t);
    @(negedge clk);
    req_addr = a; req_app = 2'(app); req_tag = 6'(tag);
    req_valid = !alt; alt_valid = alt;
    while (!(alt ? a_ready : req_ready)) @(negedge clk);
    @(posedge clk);
    #1 t = cyc;
    if (!keep) begin
      @(negedge clk);
      req_valid = 0; alt_valid = 0;
    end
  endtask

  task automatic wait_lane(input bit alt, input int lane, output int t, output int tag, output int hit);
    bit seen = 0;
    for (int k = 0; k < 1000 && !seen; k++) begin
      @(negedge clk);
      seen = alt ? a_cv[lane] : cmp_valid[lane];
    end
    t   = cyc;
    tag = alt ? int'(a_ct[lane*6 +: 6]) : int'(cmp_tag[lane*6 +: 6]);
    hit = alt ? int'(a_ch[lane]) : int'(cmp_hit[lane]);
  endtask

  task automatic summary;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int tp, t, tag, hit, t15, t22;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 ready after reset", req_ready, 1);
    chk(cmp_valid == 4'b0, "R10 no completion after reset", cmp_valid, 0);
    chk(a_ready == 1'b1, "R10 alt ready after reset", a_ready, 1);

    // closed bank, then a hit from a request differing only in channel and column bits
    push(0, mk(1, 0, 0, 0), 1, 1, 0, tp);
    wait_lane(0, 0, t, tag, hit);
    chk(t == tp + 1 + 2*T, "R4 closed-bank latency", t - tp, 1 + 2*T);
    chk(hit == 0, "R4 closed bank not a hit", hit, 0);
    chk(tag == 1, "R7 tag returned", tag, 1);
    push(0, mk(1, 0, 3, 5), 2, 2, 0, tp);
    wait_lane(0, 0, t, tag, hit);
    chk(hit == 1, "R1 R9 channel/column bits keep row hit", hit, 1);
    chk(t == tp + 1 + T, "R4 hit latency", t - tp, 1 + T);
    chk(int'(cmp_app[1:0]) == 2, "R7 app returned", cmp_app[1:0], 2);
    push(0, mk(7, 2, 0, 0), 3, 3, 0, tp);
    wait_lane(0, 2, t, tag, hit);
    chk(tag == 3, "R1 bank from bits 13:12 selects lane 2", tag, 3);
    chk(t == tp + 1 + 2*T, "R6 issue on edge after store", t - tp, 1 + 2*T);

    // alternative layout
    push(1, mk(0, 0, 1, 0), 0, 9, 0, tp);
    wait_lane(1, 1, t, tag, hit);
    chk(tag == 9, "R2 bank from bits 11:10", tag, 9);
    chk(t == tp + 1 + 2*T, "R2 closed-bank latency", t - tp, 1 + 2*T);
    push(1, mk(0, 3, 1, 2), 0, 10, 0, tp);
    wait_lane(1, 1, t, tag, hit);
    chk(hit == 1, "R2 bits 13:12 are column in alt layout", hit, 1);

    // open-row stream starving a second application
    repeat (20) @(negedge clk);
    begin
      int seq[19] = '{0, 20, 1, 2, 3, 21, 4, 22, 5, 6, 7, 8, 9, 10, 11, 12, 13, 14, 15};
      for (int i = 0; i < 19; i++) begin
        if (seq[i] >= 20) push(0, mk(9, 0, 0, seq[i] == 20 ? 0 : (seq[i] == 21 ? 10 : 12)), 2, seq[i], i != 18, t);
        else              push(0, mk(5, 0, 0, seq[i]), 1, seq[i], i != 18, t);
        if (i == 0) tp = t;
      end
    end
    t15 = -1; t22 = -1;
    for (int k = 0; k < 25 && t22 < 0; k++) begin
      wait_lane(0, 0, t, tag, hit);
      if (tag == 15) t15 = t;
      if (tag == 22) t22 = t;
    end
    chk(t15 == tp + 1 + 17*T, "R11 last hit-stream request", t15 - tp - 1, 17*T);
    chk(t22 == tp + 1 + 21*T, "R11 last starved request", t22 - tp - 1, 21*T);

    // hit overtakes an older miss; bank 0 holds row 9 now
    repeat (10) @(negedge clk);
    push(0, mk(9, 0, 0, 1), 0, 30, 1, tp);
    push(0, mk(3, 0, 0, 0), 1, 31, 1, t);
    push(0, mk(9, 0, 0, 2), 2, 32, 0, t);
    wait_lane(0, 0, t, tag, hit);
    chk(tag == 30 && t == tp + 1 + T, "R5 first request served", tag, 30);
    wait_lane(0, 0, t, tag, hit);
    chk(tag == 32, "R5 younger hit goes first", tag, 32);
    chk(t == tp + 5 + T, "R6 back-to-back bank reuse", t - tp, 5 + T);
    wait_lane(0, 0, t, tag, hit);
    chk(tag == 31 && hit == 0, "R5 older miss served last", tag, 31);

    // fill the buffer with conflicts to one bank
    repeat (10) @(negedge clk);
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (k == 24) chk(req_ready == 1'b0, "R3 ready low when full", req_ready, 0);
      req_valid = 1; req_addr = mk(k % 2, 1, 0, 0); req_tag = 6'(k); req_app = 2'(k);
    end
    @(negedge clk) req_valid = 0;
    repeat (200) @(negedge clk);
    chk(req_ready == 1'b1, "R3 ready back after drain", req_ready, 1);

    // mixed traffic checked against the model every cycle
    for (int c = 0; c < 600; c++) begin
      @(negedge clk);
      req_valid = 1'($urandom % 2);
      req_addr  = mk(int'($urandom % 3), int'($urandom % 4), int'($urandom % 4), int'($urandom % 16));
      req_tag   = 6'($urandom);
      req_app   = 2'($urandom);
    end
    @(negedge clk) req_valid = 0;
    repeat (200) @(negedge clk);
    summary();
  end
endmodule